// File: doc/BRIEF.md
# BCD Calendar Counter with Snapshot

This block keeps wall-clock time and date as seven packed-BCD bytes: seconds, minutes, hours, day of month, month, two-digit year and weekday. A one-cycle enable pulse, once per second, advances the count while the run bit of the control register is set. Each field rolls over at its own limit and carries into the next. The day limit follows the month length, with a leap February in every year divisible by four.

Software reaches the block through a byte-wide register port with address, write strobe, write data and combinational read data. To set the time, software clears the run bit, writes the six fields from seconds to year (plus the weekday) to consecutive addresses, and sets the run bit again. To read a coherent time across several bus cycles, software raises the capture bit so that all seven counters are copied into static shadow latches. It then sets the view bit so that reads of the time addresses return the latched copy and not the live counters.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, addresses 0x00 to 0x06 read 0x00, 0x00, 0x00, 0x01, 0x01, 0x00, 0x00 (seconds, minutes, hours, day, month, year, weekday). The control register (0x08) and the status register (0x09) read 0x00.
- R2: Seconds and minutes wrap from 0x59 to 0x00 and carry into the next field. Hours wrap from 0x23 to 0x00 and carry into both day and weekday.
- R3: Day wraps to 0x01 after the last day of the month (0x31, 0x30 for months 04/06/09/11, 0x28 for month 02, 0x29 for month 02 when year mod 4 is 0) and carries into month. Before the last day it simply increments.
- R4: Month wraps from 0x12 to 0x01 and carries into year. Year wraps from 0x99 to 0x00. Weekday wraps from 0x06 to 0x00.
- R5: Control bit 0 is the run bit. While it is clear, tick pulses leave every field unchanged. Status bit 1 (value 0x02) reads 1 exactly when the run bit is set.
- R6: A write to control that takes bit 6 from 0 to 1 copies all seven live fields into the shadow latches. A write that leaves bit 6 at 1 does not recapture, and the latches keep their value while the count moves on.
- R7: With control bit 7 set, reads of 0x00 to 0x06 return the shadow latches. With it clear, they return the live counters.
- R8: A write to a time address loads the byte on the next clock even while running. A tick in that same cycle is ignored for the written field, which also produces no carry. Other fields still count.
- R9: Every field counts in packed BCD: a low nibble of 9 goes to 0 and increments the high nibble (for example 0x09 to 0x10).
- R10: Control bits 1 to 5 read as 0. Addresses other than 0x00 to 0x06, 0x08 and 0x09 read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per second |
| bus_addr | input | ADDR_W (5) | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |

## Verification
The range assertions assume that software writes only legal packed-BCD values within each field's range. The bench holds to this by converting every value it writes from a binary number inside the field limits. The assertions also assume a write never lands on a day beyond the month length already held. The sweeps avoid this by writing month and year before day, and only writing days that exist in that month. Tick pulses last exactly one cycle, and the bench drives them only between bus operations, except in the deliberate same-cycle write case.

// File: rtl/bcd_cal_pkg.sv
`timescale 1ns/1ps
package bcd_cal_pkg;
   localparam int NF     = 7;   // number of time fields
   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_DAY  = 3;
   localparam int F_MON  = 4;
   localparam int F_YEAR = 5;
   localparam int F_WDAY = 6;

   typedef logic [7:0] bcd_t;

   function automatic bcd_t bcd_inc(bcd_t v);
      return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
   endfunction

   // year mod 4 == 0 : (tens*10 + units) mod 4 == (2*tens[0] + units) mod 4
   function automatic logic is_leap(bcd_t yr);
      logic [4:0] s;
      s = {3'b000, yr[4], 1'b0} + {1'b0, yr[3:0]};
      return (s[1:0] == 2'b00);
   endfunction

   function automatic bcd_t month_len(bcd_t mon, bcd_t yr);
      case (mon)
         8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic bcd_t field_lo(int i);
      return (i == F_DAY || i == F_MON) ? 8'h01 : 8'h00;
   endfunction

   function automatic bcd_t field_hi(int i);
      case (i)
         F_SEC, F_MIN: return 8'h59;
         F_HOUR:       return 8'h23;
         F_DAY:        return 8'h31;
         F_MON:        return 8'h12;
         F_YEAR:       return 8'h99;
         default:      return 8'h06;
      endcase
   endfunction
endpackage

// File: rtl/cal_field.sv
`timescale 1ns/1ps
module cal_field #(
   parameter logic [7:0] LO = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc_i,
   input  logic       wr_i,
   input  logic [7:0] wdata_i,
   input  logic [7:0] hi_i,
   output logic [7:0] val_o,
   output logic       wrap_o
);
   import bcd_cal_pkg::*;

   logic [7:0] val_q;
   logic       at_top;

   assign at_top = (val_q >= hi_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     val_q <= LO;
      else if (wr_i)  val_q <= wdata_i;
      else if (inc_i) val_q <= at_top ? LO : bcd_inc(val_q);
   end

   assign val_o  = val_q;
   assign wrap_o = inc_i & ~wr_i & at_top;
endmodule

// File: rtl/cal_snap.sv
`timescale 1ns/1ps
module cal_snap #(
   parameter int NF        = 7,
   parameter bit SHADOW_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cap_i,
   input  logic [NF-1:0][7:0]   live_i,
   output logic [NF-1:0][7:0]   shadow_o
);
   generate
      if (SHADOW_EN) begin : g_latch
         for (genvar i = 0; i < NF; i++) begin : g_f
            logic [7:0] sh_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)     sh_q <= 8'h00;
               else if (cap_i) sh_q <= live_i[i];
            end
            assign shadow_o[i] = sh_q;
         end
      end else begin : g_pass
         logic unused_ok;
         assign unused_ok = cap_i ^ clk ^ rst_n;
         assign shadow_o  = live_i;
      end
   endgenerate
endmodule

// File: rtl/bcd_calendar.sv
`timescale 1ns/1ps
module bcd_calendar #(
   parameter int ADDR_W    = 5,
   parameter int CTRL_ADDR = 8,
   parameter int STAT_ADDR = 9,
   parameter bit SHADOW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata
);
   import bcd_cal_pkg::*;

   localparam int NREG = 1 << ADDR_W;

   generate
      if (CTRL_ADDR >= NREG || STAT_ADDR >= NREG) begin : g_bad_range
         $error("control or status address does not fit ADDR_W");
      end
      if (CTRL_ADDR < NF || STAT_ADDR < NF || CTRL_ADDR == STAT_ADDR) begin : g_bad_map
         $error("control/status addresses overlap time fields or each other");
      end
   endgenerate

   logic              run_q, snap_q, view_q;
   logic              ctrl_wr, cap;
   logic [NF-1:0]     inc, wrap, fwr;
   logic [NF-1:0][7:0] hi, live_q, shadow_q;

   // control register
   assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));
   assign cap     = ctrl_wr && bus_wdata[6] && !snap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         snap_q <= 1'b0;
         view_q <= 1'b0;
      end else if (ctrl_wr) begin
         run_q  <= bus_wdata[0];
         snap_q <= bus_wdata[6];
         view_q <= bus_wdata[7];
      end
   end

   // limits and carry chain
   always_comb begin
      for (int i = 0; i < NF; i++) hi[i] = field_hi(i);
      hi[F_DAY] = month_len(live_q[F_MON], live_q[F_YEAR]);
      inc[F_SEC]  = tick_i & run_q;
      inc[F_MIN]  = wrap[F_SEC];
      inc[F_HOUR] = wrap[F_MIN];
      inc[F_DAY]  = wrap[F_HOUR];
      inc[F_MON]  = wrap[F_DAY];
      inc[F_YEAR] = wrap[F_MON];
      inc[F_WDAY] = wrap[F_HOUR];
   end

   generate
      for (genvar i = 0; i < NF; i++) begin : g_fld
         assign fwr[i] = bus_we && (bus_addr == ADDR_W'(i));
         cal_field #(.LO(field_lo(i))) u_field (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (inc[i]),
            .wr_i    (fwr[i]),
            .wdata_i (bus_wdata),
            .hi_i    (hi[i]),
            .val_o   (live_q[i]),
            .wrap_o  (wrap[i])
         );
      end
   endgenerate

   cal_snap #(.NF(NF), .SHADOW_EN(SHADOW_EN)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_i    (cap),
      .live_i   (live_q),
      .shadow_o (shadow_q)
   );

   // read mux
   always_comb begin
      bus_rdata = 8'h00;
      if (int'(bus_addr) < NF)
         bus_rdata = view_q ? shadow_q[bus_addr[2:0]] : live_q[bus_addr[2:0]];
      else if (bus_addr == ADDR_W'(CTRL_ADDR))
         bus_rdata = {view_q, snap_q, 5'b00000, run_q};
      else if (bus_addr == ADDR_W'(STAT_ADDR))
         bus_rdata = {6'b000000, run_q, 1'b0};
   end
endmodule

// File: rtl/bcd_calendar_chk.sv
`timescale 1ns/1ps
module bcd_calendar_chk #(
   parameter int ADDR_W    = 5,
   parameter int CTRL_ADDR = 8,
   parameter bit SHADOW_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              snap,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [6:0][7:0]   live,
   input logic [6:0][7:0]   shadow
);
   logic sec_wr, cap;
   assign sec_wr = bus_we && (bus_addr == '0);
   assign cap    = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR)) && bus_wdata[6] && !snap;

   a_r5_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !sec_wr) |=> $stable(live[0]));

   a_r2_sec_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (live[0][3:0] <= 4'd9) && (live[0] <= 8'h59));

   a_r3_day_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (live[3] >= 8'h01) && (live[3] <= 8'h31) && (live[3][3:0] <= 4'd9));

   a_r4_month_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (live[4] >= 8'h01) && (live[4] <= 8'h12));

   a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      sec_wr |=> (live[0] == $past(bus_wdata)));

   a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (SHADOW_EN && !cap) |=> $stable(shadow));

   a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (SHADOW_EN && cap) |=> (shadow == $past(live)));
endmodule

bind bcd_calendar bcd_calendar_chk #(
   .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .SHADOW_EN(SHADOW_EN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run_q),
   .snap      (snap_q),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .live      (live_q),
   .shadow    (shadow_q)
);

// File: tb/bcd_calendar_test.sv
`timescale 1ns/1ps
module bcd_calendar_test;
   localparam int ADDR_W = 5;
   localparam int CTRL   = 8;
   localparam int STAT   = 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_i = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_we = 1'b0;
   logic [7:0]        bus_wdata = 8'h00;
   logic [7:0]        bus_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   bcd_calendar uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   always #5 clk = ~clk;

   function automatic logic [7:0] bcd(int v);
      return 8'((v / 10) << 4) | 8'(v % 10);
   endfunction

   function automatic int dim(int m, int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [7:0] d);
      @(negedge clk);
      bus_addr = ADDR_W'(a); bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(int a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = ADDR_W'(a);
      #1 v = bus_rdata;
   endtask

   task automatic rdchk(string req, int a, logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic tick();
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
   endtask

   task automatic set_time(int s, int mi, int h, int d, int mo, int y, int wd);
      wr(CTRL, 8'h00);
      wr(5, bcd(y)); wr(4, bcd(mo));          // month/year before day
      wr(0, bcd(s)); wr(1, bcd(mi)); wr(2, bcd(h)); wr(3, bcd(d));
      wr(6, bcd(wd));
      wr(CTRL, 8'h01);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rdchk("R1", 0, 8'h00); rdchk("R1", 1, 8'h00); rdchk("R1", 2, 8'h00);
      rdchk("R1", 3, 8'h01); rdchk("R1", 4, 8'h01); rdchk("R1", 5, 8'h00);
      rdchk("R1", 6, 8'h00); rdchk("R1", CTRL, 8'h00); rdchk("R1", STAT, 8'h00);
      // R10 unmapped addresses
      rdchk("R10", 7, 8'h00); rdchk("R10", 10, 8'h00); rdchk("R10", 31, 8'h00);

      // R9 / R2 : count across an hour, compare arithmetically
      wr(CTRL, 8'h01);
      for (int t = 1; t <= 3700; t++) begin
         tick();
         rdchk("R9", 0, bcd(t % 60));
         rdchk("R2", 1, bcd((t / 60) % 60));
         rdchk("R2", 2, bcd((t / 3600) % 24));
      end

      // R2 hour wrap into day and weekday ; R4 weekday 6 -> 0
      set_time(59, 59, 23, 5, 3, 21, 6);
      tick();
      rdchk("R2", 2, 8'h00); rdchk("R2", 1, 8'h00); rdchk("R2", 0, 8'h00);
      rdchk("R2", 3, 8'h06); rdchk("R4", 6, 8'h00);

      // R3 month lengths over four years
      for (int y = 20; y < 24; y++) begin
         for (int m = 1; m <= 12; m++) begin
            set_time(59, 59, 23, dim(m, y) - 1, m, y, 2);
            tick();
            rdchk("R3", 3, bcd(dim(m, y)));
            rdchk("R3", 4, bcd(m));
            tick();                              // 23:59:59 again? no: next day rollover needs a day
            set_time(59, 59, 23, dim(m, y), m, y, 2);
            tick();
            rdchk("R3", 3, 8'h01);
            rdchk("R3", 4, bcd(m % 12 + 1));
            rdchk("R3", 5, bcd(m == 12 ? y + 1 : y));
            rdchk("R3", 6, 8'h03);
         end
      end

      // R4 year 99 -> 00 on new year
      set_time(59, 59, 23, 31, 12, 99, 4);
      tick();
      rdchk("R4", 5, 8'h00); rdchk("R4", 4, 8'h01); rdchk("R4", 3, 8'h01);
      rdchk("R4", 6, 8'h05);

      // R5 run bit and status
      set_time(7, 0, 0, 1, 1, 0, 0);
      wr(CTRL, 8'h00);
      rdchk("R5", STAT, 8'h00);
      for (int k = 0; k < 5; k++) tick();
      rdchk("R5", 0, 8'h07);
      wr(CTRL, 8'h01);
      rdchk("R5", STAT, 8'h02);
      tick();
      rdchk("R5", 0, 8'h08);

      // R6 / R7 snapshot and shadow view
      set_time(10, 20, 8, 15, 6, 24, 3);
      wr(CTRL, 8'h41);                  // rising capture bit
      for (int k = 0; k < 3; k++) tick();
      wr(CTRL, 8'hC1);                  // bit 6 held: no recapture
      rdchk("R7", 0, 8'h10); rdchk("R7", 1, 8'h20); rdchk("R7", 2, 8'h08);
      rdchk("R6", 3, 8'h15); rdchk("R6", 4, 8'h06); rdchk("R6", 5, 8'h24);
      rdchk("R6", 6, 8'h03);
      wr(CTRL, 8'h41);
      rdchk("R7", 0, 8'h13);            // live view
      wr(CTRL, 8'h01);
      wr(CTRL, 8'hC1);                  // new rising edge recaptures
      rdchk("R6", 0, 8'h13);
      tick();
      rdchk("R6", 0, 8'h13);            // shadow frozen while live moves
      wr(CTRL, 8'h81);
      rdchk("R7", 0, 8'h13);
      wr(CTRL, 8'h01);
      rdchk("R7", 0, 8'h14);
      // R10 unused control bits
      wr(CTRL, 8'hFF);
      rdchk("R10", CTRL, 8'hC1);

      // R8 write during tick
      set_time(59, 10, 5, 2, 2, 1, 1);
      @(negedge clk);
      bus_addr = 0; bus_wdata = 8'h20; bus_we = 1'b1; tick_i = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; tick_i = 1'b0;
      rdchk("R8", 0, 8'h20); rdchk("R8", 1, 8'h10);
      @(negedge clk);
      bus_addr = 1; bus_wdata = 8'h45; bus_we = 1'b1; tick_i = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; tick_i = 1'b0;
      rdchk("R8", 0, 8'h21); rdchk("R8", 1, 8'h45);

      rd(0, v);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule